// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block produces a pulse train on one output pin per channel from a single clock. A 6-bit clock divider slows the count rate, and a 10-bit counter measures out each period. The output is active at the start of each period and drops once the counter reaches the programmed duty count. A separate flag holds the output active for the whole period. Software programs each channel through a small register bus and starts or stops it with a per-channel enable pin.

Duty and period values are captured into working copies only at a period boundary, so a pulse is never cut short or stretched by a write. When the enable drops, a per-channel stop-mode bit selects what happens. In the cut mode the output goes inactive on the next clock. In the drain mode the current period runs to its end first. A build parameter adds a second channel with its own register window.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset every register reads zero and every PWM output is low.
- R2: Per channel, the control register is at byte offset 0x00 (bits 5:0 prescale P, bit 6 stop mode), the duty register is at 0x04 (bits 9:0 duty count D, bit 10 full flag) and the period register is at 0x08 (bits 9:0 period value V). A read with `bus_rd` high returns the last written value with unused bits as zero. With `bus_rd` low, or at an unmapped offset, the read data is zero. Writes to unmapped offsets change nothing.
- R3: The first clock edge that samples the enable high starts a period. A period lasts (P+1)*(V+1) cycles. The output is high for the first (P+1)*D cycles of each period while the enable stays high.
- R4: D=0 gives a constantly low output, and D>V gives a constantly high output.
- R5: With the full flag set, the output is high for the whole period whatever D holds.
- R6: Writes to P, D, V or the full flag take effect only at the start of the next period. The output never rises except at a period start.
- R7: With the stop-mode bit at 1, a low enable forces the output low from the next clock edge, and counting stops.
- R8: With the stop-mode bit at 0, a low enable lets the current period finish unchanged. After that the output stays low.
- R9: With the second-channel parameter set, channel 1 uses the same layout at byte offsets 0x10, 0x14 and 0x18, and runs independently of channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | 5 | Byte address; bit 4 selects the channel |
| bus_wdata | input | 11 | Write data |
| bus_rdata | output | 11 | Read data, combinational |
| chan_en | input | NUM_CH | Per-channel run enable |
| pwm_out | output | NUM_CH | Per-channel pulse output |

## Verification
The hardest case to reach from the ports is a register write that lands inside a running period. The write must come after the active part is over, so that only the working copy stops the new duty value from lengthening the current pulse. The bench writes a larger duty count in a chosen cycle of a measured period. It then counts the active cycles of that period and of the next one separately. The same cycle-indexed sampling drops the enable in a known cycle of a period. This checks that the drain mode keeps the pulse going to its end and that the cut mode ends it on the next edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PS_W     = 6;
  localparam int CNT_W    = 10;
  localparam int STOP_BIT = PS_W;
  localparam int FULL_BIT = CNT_W;
  localparam int BUS_DW   = FULL_BIT + 1;
  localparam int BUS_AW   = 5;
  localparam int CH_BIT   = BUS_AW - 1;

  localparam logic [CH_BIT-1:0] OFS_CTRL = 4'h0;
  localparam logic [CH_BIT-1:0] OFS_DUTY = 4'h4;
  localparam logic [CH_BIT-1:0] OFS_PER  = 4'h8;

  typedef struct packed {
    logic            stop_cut;
    logic [PS_W-1:0] prescale;
  } ctrl_t;

  typedef struct packed {
    logic             full;
    logic [CNT_W-1:0] dc;
  } duty_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_duty,
  input  logic              wr_per,
  input  logic [BUS_DW-1:0] wdata,
  output ctrl_t             ctrl_q,
  output duty_t             duty_q,
  output logic [CNT_W-1:0]  per_q
);
  ctrl_t            ctrl_d;
  duty_t            duty_d;
  logic [CNT_W-1:0] per_d;

  always_comb begin
    ctrl_d.stop_cut = wdata[STOP_BIT];
    ctrl_d.prescale = wdata[PS_W-1:0];
    duty_d.full     = wdata[FULL_BIT];
    duty_d.dc       = wdata[CNT_W-1:0];
    per_d           = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_duty) duty_q <= duty_d;
      if (wr_per)  per_q  <= per_d;
    end
  end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  ctrl_t            ctrl,
  input  duty_t            duty,
  input  logic [CNT_W-1:0] per,
  output logic             pwm,
  output logic             boundary
);
  logic             run_q, run_d;
  logic [PS_W-1:0]  pcnt_q, pcnt_d, ps_sh_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, pv_sh_q;
  duty_t            duty_sh_q;
  logic             tick, wrap, start, cut, load;

  always_comb begin
    tick  = run_q && (pcnt_q == ps_sh_q);
    wrap  = tick && (cnt_q == pv_sh_q);
    start = !run_q && en;
    cut   = run_q && !en && ctrl.stop_cut;
    load  = start || (wrap && en);

    run_d = run_q;
    if (cut)               run_d = 1'b0;
    else if (start)        run_d = 1'b1;
    else if (wrap && !en)  run_d = 1'b0;

    if (load || cut || !run_q || tick) pcnt_d = '0;
    else                               pcnt_d = pcnt_q + 1'b1;

    if (load || cut || !run_q || wrap) cnt_d = '0;
    else if (tick)                     cnt_d = cnt_q + 1'b1;
    else                               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      pcnt_q    <= '0;
      cnt_q     <= '0;
      ps_sh_q   <= '0;
      pv_sh_q   <= '0;
      duty_sh_q <= '0;
    end else begin
      run_q  <= run_d;
      pcnt_q <= pcnt_d;
      cnt_q  <= cnt_d;
      if (load) begin
        ps_sh_q   <= ctrl.prescale;
        pv_sh_q   <= per;
        duty_sh_q <= duty;
      end
    end
  end

  assign pwm      = run_q && (duty_sh_q.full || (cnt_q < duty_sh_q.dc));
  assign boundary = load;
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
#(
  parameter bit DUAL   = 1'b1,
  parameter int NUM_CH = DUAL ? 2 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] chan_en,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_sn;
  logic [CH_BIT-1:0] ofs;
  ctrl_t             ctrl_arr [NUM_CH];
  duty_t             duty_arr [NUM_CH];
  logic [CNT_W-1:0]  per_arr  [NUM_CH];
  logic [NUM_CH-1:0] stop_vec;
  logic [NUM_CH-1:0] bnd_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];
  assign ofs    = bus_addr[CH_BIT-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = bus_wr && (bus_addr[CH_BIT] == 1'(i));

    pwm_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_sn),
      .wr_ctrl (hit && (ofs == OFS_CTRL)),
      .wr_duty (hit && (ofs == OFS_DUTY)),
      .wr_per  (hit && (ofs == OFS_PER)),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_arr[i]),
      .duty_q  (duty_arr[i]),
      .per_q   (per_arr[i])
    );

    pwm_chan_core u_core (
      .clk      (clk),
      .rst_n    (rst_sn),
      .en       (chan_en[i]),
      .ctrl     (ctrl_arr[i]),
      .duty     (duty_arr[i]),
      .per      (per_arr[i]),
      .pwm      (pwm_out[i]),
      .boundary (bnd_vec[i])
    );

    assign stop_vec[i] = ctrl_arr[i].stop_cut;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (bus_addr[CH_BIT] == 1'(i)) begin
          case (ofs)
            OFS_CTRL: bus_rdata = BUS_DW'(ctrl_arr[i]);
            OFS_DUTY: bus_rdata = BUS_DW'(duty_arr[i]);
            OFS_PER:  bus_rdata = BUS_DW'(per_arr[i]);
            default:  bus_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chan_en,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] stop_cut,
  input logic [NUM_CH-1:0] boundary,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_rdata
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r7_cut_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en[i] && stop_cut[i]) |=> !pwm_out[i]);

    a_r8_low_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en[i] && !pwm_out[i]) |=> !pwm_out[i]);

    a_r6_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[i]) |-> $past(boundary[i]));
  end

  a_r2_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && $past(bus_rd) && $stable(bus_addr) && !$past(bus_wr))
      |-> $stable(bus_rdata));
endmodule

bind pwm_prescaled pwm_prescaled_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .chan_en   (chan_en),
  .pwm_out   (pwm_out),
  .stop_cut  (stop_vec),
  .boundary  (bnd_vec),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/tb_pwm_prescaled.sv
module tb_pwm_prescaled;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [4:0]  bus_addr;
  logic [10:0] bus_wdata;
  logic [10:0] bus_rdata;
  logic [1:0]  chan_en;
  logic [1:0]  pwm_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pwm_prescaled dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_en(chan_en), .pwm_out(pwm_out)
  );

  // {prescale, period, duty, full, requirement}
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{0, 9, 3, 0, 3}, '{2, 4, 2, 0, 3}, '{63, 3, 1, 0, 3},
    '{1, 7, 0, 0, 4}, '{0, 5, 9, 0, 4},
    '{3, 3, 1, 1, 5}, '{0, 1023, 0, 1, 5}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [10:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [4:0] a, input int exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    check(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic count_high(input int ch, input int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) highs++;
    end
  endtask

  // leaves channel 0 idle with cut mode selected
  task automatic halt0(input int ps);
    @(negedge clk);
    chan_en[0] = 1'b0;
    wr(5'h00, 11'((1 << 6) | ps));
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int h1, h2, ps, pv, dc, fl, n, exp;
    string tag;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; chan_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(pwm_out == 2'b00, "R1", int'(pwm_out), 0);
    rd_check(5'h00, 0, "R1"); rd_check(5'h04, 0, "R1"); rd_check(5'h08, 0, "R1");
    rd_check(5'h10, 0, "R1"); rd_check(5'h14, 0, "R1"); rd_check(5'h18, 0, "R1");

    // R2 readback masks, unmapped offset, read enable low
    wr(5'h00, 11'h7FF); wr(5'h04, 11'h7FF); wr(5'h08, 11'h7FF);
    wr(5'h0C, 11'h155);
    rd_check(5'h00, 'h07F, "R2"); rd_check(5'h04, 'h7FF, "R2");
    rd_check(5'h08, 'h3FF, "R2"); rd_check(5'h0C, 0, "R2");
    @(negedge clk); bus_rd = 1'b0; bus_addr = 5'h04; #1;
    check(bus_rdata == 0, "R2", int'(bus_rdata), 0);

    // R3 R4 R5 table walk over two periods
    for (int v = 0; v < NV; v++) begin
      ps = VEC[v][0]; pv = VEC[v][1]; dc = VEC[v][2]; fl = VEC[v][3];
      tag = $sformatf("R%0d", VEC[v][4]);
      halt0(ps);
      wr(5'h04, 11'((fl << 10) | dc));
      wr(5'h08, 11'(pv));
      @(negedge clk);
      chan_en[0] = 1'b1;
      n   = (ps + 1) * (pv + 1);
      exp = fl ? n : ((dc > pv ? pv + 1 : dc) * (ps + 1));
      count_high(0, n, h1);
      count_high(0, n, h2);
      check(h1 == exp, tag, h1, exp);
      check(h2 == exp, tag, h2, exp);
    end

    // R6 mid-period write held back until next period
    halt0(0);
    wr(5'h04, 11'd2); wr(5'h08, 11'd9);
    @(negedge clk); chan_en[0] = 1'b1;
    h1 = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (bus_wr) bus_wr = 1'b0;
      if (pwm_out[0]) h1++;
      if (k == 4) begin bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = 11'd8; end
    end
    bus_wr = 1'b0;
    count_high(0, 10, h2);
    check(h1 == 2, "R6", h1, 2);
    check(h2 == 8, "R6", h2, 8);

    // R8 drain mode: finish the period, then stay low
    halt0(0);
    wr(5'h00, 11'd0);
    @(negedge clk); chan_en[0] = 1'b1;
    count_high(0, 3, h1);
    chan_en[0] = 1'b0;
    count_high(0, 5, h1);
    check(h1 == 5, "R8", h1, 5);
    count_high(0, 12, h2);
    check(h2 == 0, "R8", h2, 0);

    // R7 cut mode: low from the next edge
    halt0(0);
    @(negedge clk); chan_en[0] = 1'b1;
    count_high(0, 3, h1);
    check(h1 == 3, "R7", h1, 3);
    chan_en[0] = 1'b0;
    count_high(0, 17, h2);
    check(h2 == 0, "R7", h2, 0);

    // R9 second channel window
    wr(5'h10, 11'd1); wr(5'h14, 11'd3); wr(5'h18, 11'd4);
    rd_check(5'h14, 3, "R9"); rd_check(5'h04, 8, "R9");
    @(negedge clk); chan_en[1] = 1'b1;
    h1 = 0; h2 = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (pwm_out[1]) h1++;
      if (pwm_out[0]) h2++;
    end
    check(h1 == 6, "R9", h1, 6);
    check(h2 == 0, "R9", h2, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule